// File: doc/BRIEF.md
# DRAM ECC error status and logger

This block collects ECC error events from the per-channel checkers of a two-channel DRAM controller and holds them for software. Each checker pulses a correctable or an uncorrectable indication for one cycle and supplies the failing column, row, bank, rank and syndrome alongside it. The block keeps one 64-bit log per channel and one shared status register with a correctable flag and an uncorrectable flag. Software clears a flag by writing 1 to it. A level input turns the second channel off so that only channel 0 is observed.

Each channel log is a three-state machine. The states are LOG_EMPTY (nothing held, the log reads all zeros), LOG_CE (holds a correctable error) and LOG_UE (holds an uncorrectable error). The transitions are: *capture-ce* (LOG_EMPTY to LOG_CE on a correctable pulse), *capture-ue* (LOG_EMPTY to LOG_UE on an uncorrectable pulse), *overwrite* (LOG_CE to LOG_UE on an uncorrectable pulse), *clear-ce* and *clear-ue* (LOG_CE or LOG_UE back to LOG_EMPTY when software writes 1 to the matching status flag), and *channel-off* (any state to LOG_EMPTY while the channel is disabled). Within one edge the clear is applied first and the event second, so an event in the same cycle as a clear is kept.

The register port is read combinationally. Address 0 is status, address 1 is the channel 0 log, address 2 is the channel 1 log and address 3 reads zero. Software forms a global rank as channel × 4 + rank.

Top module: `mem_ecc_logger`

## Requirements
- R1: After reset the status register and both logs read all zeros.
- R2: Status (address 0) bit 0 is the correctable flag and bit 1 the uncorrectable flag. A pulse from an enabled channel sets the matching flag on the next edge. Bits 63:2 of a status read are zero.
- R3: Writing 1 to a status flag clears it. Writing 0 leaves it unchanged, and writes to status bits 15:2 have no effect.
- R4: When an event and a clearing write for the same flag occur in the same cycle, the flag is set after the edge.
- R5: A log read gives the column in bits 63:48, row in 47:32, bank in 31:29, rank in 28:27, syndrome in 23:16, the uncorrectable bit in bit 1 and the correctable bit in bit 0. All other bits are zero. An empty log reads zero. Channel 0 is at address 1, channel 1 at address 2, and address 3 reads zero.
- R6: An uncorrectable pulse on a channel whose log holds a correctable error replaces the whole log with the new error's fields and the uncorrectable bit.
- R7: A log holding an error keeps it unchanged when a correctable pulse arrives, and a log holding an uncorrectable error also keeps it when another uncorrectable pulse arrives. The status flag is still set.
- R8: Writing 1 to a status flag also empties every log that holds that kind of error, so the log can capture again.
- R9: While the dual-channel-disable input is high, channel 1 pulses set no flag and are not logged, and the channel 1 log is emptied on the next edge.
- R10: Simultaneous correctable and uncorrectable pulses on one channel set both flags, and the log captures the error as uncorrectable.
- R11: Writes to addresses other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dual_off | input | 1 | High: only channel 0 is active |
| evt_ce | input | NCH | Correctable-error pulse, one bit per channel |
| evt_ue | input | NCH | Uncorrectable-error pulse, one bit per channel |
| evt_col | input | NCH*16 | Failing column address per channel |
| evt_row | input | NCH*16 | Failing row address per channel |
| evt_bank | input | NCH*3 | Failing bank per channel |
| evt_rank | input | NCH*2 | Failing rank within the channel |
| evt_synd | input | NCH*8 | ECC syndrome per channel |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data (status flags) |
| reg_rdata | output | 64 | Read data for reg_addr |

## Verification
The hardest situation to reach is a log that already holds an error at the exact edge where a new pulse and a clearing write arrive together. That is where the overwrite, the keep-first rule and the precedence of events over clears all apply. The bench reaches it with a fixed preamble: a clear-all write, then a pulse that loads the held kind (none, correctable or uncorrectable). It then sweeps every combination of pulse pattern and written clear bits in the following cycle, on both channels at once. After each edge it predicts all four readable addresses from the requirements.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/100ps
package ecc_log_pkg;
    localparam int COL_W  = 16;
    localparam int ROW_W  = 16;
    localparam int BANK_W = 3;
    localparam int RANK_W = 2;
    localparam int SYN_W  = 8;
    localparam int LOG_W  = 64;
    localparam int STAT_W = 16;

    localparam int FLAG_CE = 0;
    localparam int FLAG_UE = 1;
    localparam int ADDR_STATUS = 0;

    typedef enum logic [1:0] {
        LOG_EMPTY = 2'd0,
        LOG_CE    = 2'd1,
        LOG_UE    = 2'd2
    } log_state_e;

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [RANK_W-1:0] rank;
        logic [SYN_W-1:0]  synd;
    } evt_info_t;

    // Field placement is decoded by software; it must not move.
    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic [BANK_W-1:0] bank;
        logic [RANK_W-1:0] rank;
        logic [2:0]        pad_hi;
        logic [SYN_W-1:0]  synd;
        logic [13:0]       pad_lo;
        logic              ue;
        logic              ce;
    } errlog_t;
endpackage

// File: rtl/ecc_chan_log.sv
`timescale 1ns/100ps
module ecc_chan_log
    import ecc_log_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      ce,
    input  logic      ue,
    input  evt_info_t info,
    input  logic [1:0] clr,
    output errlog_t   log_o
);
    log_state_e state_q;
    log_state_e state_d;
    log_state_e state_kept;
    evt_info_t  info_q;
    logic       capture;

    // Clear is resolved first, then the event acts on what is left.
    always_comb begin
        state_kept = state_q;
        unique case (state_q)
            LOG_EMPTY: state_kept = LOG_EMPTY;
            LOG_CE:    if (clr[FLAG_CE]) state_kept = LOG_EMPTY;
            LOG_UE:    if (clr[FLAG_UE]) state_kept = LOG_EMPTY;
            default:   state_kept = LOG_EMPTY;
        endcase

        state_d = state_kept;
        capture = 1'b0;
        if (!en) begin
            state_d = LOG_EMPTY;
        end else if (ue && state_kept != LOG_UE) begin
            state_d = LOG_UE;
            capture = 1'b1;
        end else if (ce && !ue && state_kept == LOG_EMPTY) begin
            state_d = LOG_CE;
            capture = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LOG_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       info_q <= '0;
        else if (capture) info_q <= info;
    end

    always_comb begin
        log_o = '0;
        unique case (state_q)
            LOG_EMPTY: log_o = '0;
            LOG_CE, LOG_UE: begin
                log_o.col  = info_q.col;
                log_o.row  = info_q.row;
                log_o.bank = info_q.bank;
                log_o.rank = info_q.rank;
                log_o.synd = info_q.synd;
                log_o.ue   = (state_q == LOG_UE);
                log_o.ce   = (state_q == LOG_CE);
            end
            default: log_o = '0;
        endcase
    end
endmodule

// File: rtl/ecc_status_reg.sv
`timescale 1ns/100ps
module ecc_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set_i,
    input  logic [1:0] clr_i,
    output logic [1:0] flags_o
);
    logic [1:0] flags_q;

    // Set dominates clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/ecc_reg_read.sv
`timescale 1ns/100ps
module ecc_reg_read
    import ecc_log_pkg::*;
#(
    parameter  int NCH = 2,
    localparam int AW  = $clog2(NCH + 1)
) (
    input  logic [AW-1:0]             addr,
    input  logic [1:0]                flags,
    input  logic [NCH-1:0][LOG_W-1:0] logs,
    output logic [LOG_W-1:0]          rdata
);
    always_comb begin
        rdata = '0;
        if (addr == AW'(ADDR_STATUS)) rdata = LOG_W'(flags);
        for (int i = 0; i < NCH; i++) begin
            if (addr == AW'(i + 1)) rdata = logs[i];
        end
    end
endmodule

// File: rtl/mem_ecc_logger.sv
`timescale 1ns/100ps
module mem_ecc_logger
    import ecc_log_pkg::*;
#(
    parameter  int NCH = 2,
    localparam int AW  = $clog2(NCH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dual_off,
    input  logic [NCH-1:0]        evt_ce,
    input  logic [NCH-1:0]        evt_ue,
    input  logic [NCH*COL_W-1:0]  evt_col,
    input  logic [NCH*ROW_W-1:0]  evt_row,
    input  logic [NCH*BANK_W-1:0] evt_bank,
    input  logic [NCH*RANK_W-1:0] evt_rank,
    input  logic [NCH*SYN_W-1:0]  evt_synd,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [STAT_W-1:0]     reg_wdata,
    output logic [LOG_W-1:0]      reg_rdata
);
    logic [NCH-1:0]            ch_en;
    logic [NCH-1:0][LOG_W-1:0] chan_log;
    logic [1:0]                clr_bits;
    logic [1:0]                set_bits;
    logic [1:0]                flags_q;
    logic                      unused_wdata;

    assign clr_bits = (reg_wr && reg_addr == AW'(ADDR_STATUS)) ? reg_wdata[1:0] : 2'b00;
    assign unused_wdata = ^reg_wdata[STAT_W-1:2];

    assign set_bits[FLAG_CE] = |(evt_ce & ch_en);
    assign set_bits[FLAG_UE] = |(evt_ue & ch_en);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        evt_info_t info;
        errlog_t   lg;

        if (g == 0) begin : g_main
            assign ch_en[g] = 1'b1;
        end else begin : g_aux
            assign ch_en[g] = !dual_off;
        end

        assign info.col  = evt_col[g*COL_W +: COL_W];
        assign info.row  = evt_row[g*ROW_W +: ROW_W];
        assign info.bank = evt_bank[g*BANK_W +: BANK_W];
        assign info.rank = evt_rank[g*RANK_W +: RANK_W];
        assign info.synd = evt_synd[g*SYN_W +: SYN_W];

        ecc_chan_log u_log (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ch_en[g]),
            .ce    (evt_ce[g]),
            .ue    (evt_ue[g]),
            .info  (info),
            .clr   (clr_bits),
            .log_o (lg)
        );
        assign chan_log[g] = lg;
    end

    ecc_status_reg u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_bits),
        .clr_i   (clr_bits),
        .flags_o (flags_q)
    );

    ecc_reg_read #(.NCH(NCH)) u_read (
        .addr  (reg_addr),
        .flags (flags_q),
        .logs  (chan_log),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/ecc_logger_chk.sv
`timescale 1ns/100ps
module ecc_logger_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  evt_ce,
    input logic [1:0]  evt_ue,
    input logic        dual_off,
    input logic [1:0]  wr_clr,
    input logic [1:0]  status,
    input logic [63:0] log0,
    input logic [63:0] log1
);
    AST_CE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ce[0] |=> status[0]); // R2
    AST_ZERO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] && !wr_clr[1] |=> status[1]); // R3
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ue[0] && wr_clr[1] |=> status[1]); // R4
    AST_UE_OVERWRITES_CE: assert property (@(posedge clk) disable iff (!rst_n)
        log0[0] && evt_ue[0] |=> log0[1]); // R6
    AST_UE_LOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        log0[1] && !wr_clr[1] |=> $stable(log0)); // R7
    AST_CLEAR_EMPTIES_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        log0[0] && wr_clr[0] && !evt_ce[0] && !evt_ue[0] |=> log0 == 64'd0); // R8
    AST_CH1_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        dual_off |=> log1 == 64'd0); // R9
    AST_CH1_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dual_off && evt_ce[1] && !evt_ce[0] && !status[0] |=> !status[0]); // R9
    AST_BOTH_PULSES_UE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_ce[0] && evt_ue[0] && !log0[1] |=> log0[1:0] == 2'b10); // R10
endmodule

bind mem_ecc_logger ecc_logger_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_ce   (evt_ce[1:0]),
    .evt_ue   (evt_ue[1:0]),
    .dual_off (dual_off),
    .wr_clr   (clr_bits),
    .status   (flags_q),
    .log0     (chan_log[0]),
    .log1     (chan_log[1])
);

// File: tb/mem_ecc_logger_bench.sv
`timescale 1ns/100ps
module mem_ecc_logger_bench;
    import ecc_log_pkg::*;
    localparam int NCH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                  dual_off;
    logic [NCH-1:0]        evt_ce, evt_ue;
    logic [NCH*COL_W-1:0]  evt_col;
    logic [NCH*ROW_W-1:0]  evt_row;
    logic [NCH*BANK_W-1:0] evt_bank;
    logic [NCH*RANK_W-1:0] evt_rank;
    logic [NCH*SYN_W-1:0]  evt_synd;
    logic                  reg_wr;
    logic [1:0]            reg_addr;
    logic [15:0]           reg_wdata;
    logic [63:0]           reg_rdata;

    mem_ecc_logger u_mem_ecc_logger (
        .clk(clk), .rst_n(rst_n), .dual_off(dual_off),
        .evt_ce(evt_ce), .evt_ue(evt_ue), .evt_col(evt_col), .evt_row(evt_row),
        .evt_bank(evt_bank), .evt_rank(evt_rank), .evt_synd(evt_synd),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    logic d_off = 1'b0;

    // model: 0 empty, 1 correctable held, 2 uncorrectable held
    int          m_st  [NCH];
    logic [63:0] m_img [NCH];
    logic [1:0]  m_flags;

    function automatic logic [15:0] f_col(int s);  return 16'(s * 307 + 2565); endfunction
    function automatic logic [15:0] f_row(int s);  return 16'(s * 1873 + 4660); endfunction
    function automatic logic [2:0]  f_bank(int s); return 3'(s); endfunction
    function automatic logic [1:0]  f_rank(int s); return 2'(s >> 1); endfunction
    function automatic logic [7:0]  f_synd(int s); return 8'(s * 37 + 5); endfunction

    // R5 layout: col 63:48, row 47:32, bank 31:29, rank 28:27, synd 23:16
    function automatic logic [63:0] img(int s);
        return {f_col(s), f_row(s), f_bank(s), f_rank(s), 3'b000, f_synd(s), 16'h0000};
    endfunction

    function automatic logic [63:0] expect_at(int a);
        if (a == 0) return {62'd0, m_flags};
        if (a == 1 || a == 2) begin
            if (m_st[a-1] == 0) return 64'd0;
            return m_img[a-1] | ((m_st[a-1] == 2) ? 64'd2 : 64'd1);
        end
        return 64'd0;
    endfunction

    task automatic model_update(input logic [1:0] ce, input logic [1:0] ue,
                                input int s0, input int s1, input logic [1:0] clr);
        logic sc, su;
        sc = 1'b0; su = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            int st;
            int sd;
            logic en;
            sd = (c == 0) ? s0 : s1;
            en = (c == 0) || !d_off;
            st = m_st[c];
            if (st == 1 && clr[0]) st = 0;
            if (st == 2 && clr[1]) st = 0;
            if (!en) st = 0;
            else if (ue[c] && st != 2) begin st = 2; m_img[c] = img(sd); end
            else if (ce[c] && !ue[c] && st == 0) begin st = 1; m_img[c] = img(sd); end
            m_st[c] = st;
            if (en && ce[c]) sc = 1'b1;
            if (en && ue[c]) su = 1'b1;
        end
        m_flags = (m_flags & ~clr) | {su, sc};
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a < 4; a++) begin
            logic [63:0] e;
            reg_addr = 2'(a);
            #0.4;
            e = expect_at(a);
            n_chk++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, reg_rdata, e);
            end
        end
    endtask

    task automatic step(input logic [1:0] ce, input logic [1:0] ue, input int s0, input int s1,
                        input logic wr, input logic [1:0] addr, input logic [15:0] wd,
                        input string tag);
        @(negedge clk);
        dual_off = d_off;
        evt_ce = ce;
        evt_ue = ue;
        for (int c = 0; c < NCH; c++) begin
            int sd;
            sd = (c == 0) ? s0 : s1;
            evt_col[c*COL_W +: COL_W]    = f_col(sd);
            evt_row[c*ROW_W +: ROW_W]    = f_row(sd);
            evt_bank[c*BANK_W +: BANK_W] = f_bank(sd);
            evt_rank[c*RANK_W +: RANK_W] = f_rank(sd);
            evt_synd[c*SYN_W +: SYN_W]   = f_synd(sd);
        end
        reg_wr = wr;
        reg_addr = addr;
        reg_wdata = wd;
        @(posedge clk);
        model_update(ce, ue, s0, s1, (wr && addr == 2'd0) ? wd[1:0] : 2'b00);
        #0.5;
        evt_ce = '0;
        evt_ue = '0;
        reg_wr = 1'b0;
        check_all(tag);
    endtask

    function automatic string sweep_tag(int hs, int ev, int cl);
        if (ev == 3) return "R10";
        if (hs == 1 && ev == 2) return "R6";
        if (hs != 0 && ev != 0) return "R7";
        if (cl != 0 && ev != 0) return "R4";
        if (cl != 0) return "R8";
        return "R3";
    endfunction

    initial begin
        #1000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        dual_off = 1'b0; evt_ce = '0; evt_ue = '0;
        evt_col = '0; evt_row = '0; evt_bank = '0; evt_rank = '0; evt_synd = '0;
        reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_img[c] = '0; end
        m_flags = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2: correctable on channel 0 only; R5: uncorrectable on channel 1 at address 2
        step(2'b01, 2'b00, 5, 0, 1'b0, 2'd0, 16'h0, "R2");
        step(2'b00, 2'b10, 0, 9, 1'b0, 2'd0, 16'h0, "R5");

        // R11: writes elsewhere are ignored
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd1, 16'hFFFF, "R11");
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd2, 16'hFFFF, "R11");
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd3, 16'hFFFF, "R11");

        // R3: zeros and upper bits do nothing; ones clear
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd0, 16'h0000, "R3");
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd0, 16'hFFFC, "R3");
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd0, 16'h0001, "R8");
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd0, 16'h0002, "R8");

        // sweep: held kind x pulse pattern x written clear bits, both channels
        for (int hs = 0; hs < 3; hs++) begin
            for (int ev = 0; ev < 4; ev++) begin
                for (int cl = 0; cl < 4; cl++) begin
                    int k;
                    logic b0, b1;
                    k = hs * 16 + ev * 4 + cl;
                    b0 = ev[0];
                    b1 = ev[1];
                    step(2'b00, 2'b00, 0, 0, 1'b1, 2'd0, 16'h0003, "R8");
                    if (hs == 1) step(2'b11, 2'b00, k + 10, k + 40, 1'b0, 2'd0, 16'h0, "R5");
                    if (hs == 2) step(2'b00, 2'b11, k + 11, k + 41, 1'b0, 2'd0, 16'h0, "R5");
                    step({b0, b0}, {b1, b1}, k + 70, k + 100, 1'b1, 2'd0, 16'(cl),
                         sweep_tag(hs, ev, cl));
                end
            end
        end

        // R9: second channel disabled
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd0, 16'h0003, "R8");
        step(2'b00, 2'b11, 21, 22, 1'b0, 2'd0, 16'h0, "R5");
        step(2'b00, 2'b00, 0, 0, 1'b1, 2'd0, 16'h0002, "R8");
        d_off = 1'b1;
        step(2'b00, 2'b10, 0, 23, 1'b0, 2'd0, 16'h0, "R9");
        step(2'b10, 2'b00, 0, 24, 1'b0, 2'd0, 16'h0, "R9");
        step(2'b01, 2'b00, 25, 0, 1'b0, 2'd0, 16'h0, "R9");
        d_off = 1'b0;
        step(2'b00, 2'b10, 0, 26, 1'b0, 2'd0, 16'h0, "R9");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule